// File: doc/BRIEF.md
# System Clock Source Switch with Slewed Post-Divider

This block chooses which of up to eight clock sources drives the system clock, and it applies a 4-bit post-divider to that clock. Software programs it through two 32-bit registers. One is the selection register. Software places a source code in it and sets a switch-request bit. The block then checks whether the chosen source reports ready. If it does, the block holds for a fixed settling window and commits the change. If it does not, the request is dropped and the running source stays selected. In both cases the request bit clears itself when the block has finished.

The other register is the divider register. It holds a target post-divider value, two direction-specific slew enables and a slew interval. When slewing is enabled for the direction of a change, the applied divider moves toward the target by one step per interval, so the load seen by the supply changes gradually. When slewing is not enabled for that direction, the applied divider jumps to the target in one move. A busy bit reads high for as long as the applied divider differs from the target. Both registers are protected: a write takes effect only if an unlock pulse has armed the block since the previous write attempt.

Top module: `clksw_top`

## Requirements
- R1: After reset the selection register reads 0, so the source is 0 and no request is pending. The divider register reads 0 and `sys_ratio` is 1.
- R2: A write is accepted only if `unlock_arm` was pulsed after the previous write attempt. Every write attempt, accepted or not, disarms the block. A write that is not accepted changes neither register.
- R3: Selection register layout: bit 0 is the switch request, bits 10:8 hold the requested source and bits 14:12 read back the current source. For a ready source that differs from the current one, the current source and `sys_src` update, and the request bit clears, SW_LAT+1 clock edges after the write edge.
- R4: If the requested source is not ready when the request is examined, the request bit clears on the following edge and the current source keeps its old value.
- R5: If the requested source stops reporting ready during the settling window, the request is rejected at the end of the window, the request bit clears and the current source is unchanged.
- R6: A request that names the current source clears the request bit on the edge after the write and changes nothing else.
- R7: Writes to the selection register while a request is pending are ignored.
- R8: Divider register layout: bit 0 is busy (read-only), bit 1 enables slewing for moves to a smaller divider field, bit 2 enables slewing for moves to a larger one, bits 15:8 hold the slew interval S, and bits 23:20 hold the target divider field. `sys_ratio` equals the applied field plus one.
- R9: When slewing is not enabled for the direction of a change, the applied divider equals the target on the edge after the write.
- R10: When slewing is enabled for the direction of a change, the applied field moves by exactly one every S+1 edges. The first step lands S+1 edges after the write edge, and steps continue until the field reaches the target.
- R11: The busy bit reads 1 exactly while the applied divider differs from the target.
- R12: Bits 23:20 of the divider register read back the target value that was written, not the applied value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| unlock_arm | input | 1 | Pulse that arms the next register write |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the selection register, 1 selects the divider register |
| wr_data | input | 32 | Write data |
| src_ready | input | 8 | Per-source ready (present and stable) flags |
| mux_rd | output | 32 | Selection register readback |
| slew_rd | output | 32 | Divider register readback |
| sys_src | output | 3 | Source currently driving the system clock |
| sys_ratio | output | 5 | Applied post-divide ratio (field plus one) |

## Verification
The bench checks the source readback on both sides of the commit edge. A settling counter that is off by one therefore shows up as a switch one cycle early or late. It removes the ready flag in the middle of the settling window; a design that checks readiness only at the start would switch to a dead source. It writes the selection register again while a request is still pending; a design that accepts that write would retarget the switch in flight. For the divider, it samples the applied ratio on each step edge and the busy bit on the cycle when slewing ends. It also reverses direction while only the opposite slew enable is set. A design that ignores direction would step where it should jump, and a design with a wrong interval would put each step on the wrong cycle.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
  localparam int SRC_W    = 3;
  localparam int NSRC     = 1 << SRC_W;
  localparam int DIV_W    = 4;
  // selection register fields
  localparam int SWEN_BIT = 0;
  localparam int NEW_LSB  = 8;
  localparam int CUR_LSB  = 12;
  // divider register fields
  localparam int BUSY_BIT = 0;
  localparam int DN_BIT   = 1;
  localparam int UP_BIT   = 2;
  localparam int STEP_LSB = 8;
  localparam int DIV_LSB  = 20;

  typedef enum logic [0:0] {SW_IDLE, SW_HOLD} sw_state_e;

  // ratio applied for a divider field
  function automatic logic [DIV_W:0] ratio_of(input logic [DIV_W-1:0] fld);
    return {1'b0, fld} + 1'b1;
  endfunction

  // one unit toward the target
  function automatic logic [DIV_W-1:0] step_toward(input logic [DIV_W-1:0] cur,
                                                   input logic [DIV_W-1:0] tgt);
    return (tgt > cur) ? cur + 1'b1 : cur - 1'b1;
  endfunction

  // is slewing enabled for the direction cur -> tgt
  function automatic logic slew_allowed(input logic [DIV_W-1:0] cur,
                                        input logic [DIV_W-1:0] tgt,
                                        input logic up_en, input logic dn_en);
    return (tgt > cur) ? up_en : dn_en;
  endfunction
endpackage

// File: rtl/clksw_unlock.sv
module clksw_unlock (
  input  logic clk,
  input  logic rst_n,
  input  logic unlock_arm,
  input  logic wr_en,
  output logic armed,
  output logic wr_ok
);
  // any write attempt consumes the arm, whether or not it was armed
  always_ff @(posedge clk) begin
    if (!rst_n)          armed <= 1'b0;
    else if (wr_en)      armed <= 1'b0;
    else if (unlock_arm) armed <= 1'b1;
  end

  assign wr_ok = wr_en && armed;
endmodule

// File: rtl/clksw_switch_fsm.sv
module clksw_switch_fsm
  import clksw_pkg::*;
#(
  parameter int SW_LAT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ok,
  input  logic [SRC_W-1:0] new_in,
  input  logic             swen_in,
  input  logic [NSRC-1:0]  src_ready,
  output logic [SRC_W-1:0] cur_src,
  output logic [SRC_W-1:0] new_src,
  output logic             swen
);
  localparam int CNT_W = $clog2(SW_LAT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SW_LAT - 1);

  sw_state_e        st;
  logic [CNT_W-1:0] cnt;

  // named events
  logic tgt_ready, same_src, take_write;
  logic start_ev, quit_ev, window_end, commit_ev;

  assign tgt_ready  = src_ready[new_src];
  assign same_src   = (new_src == cur_src);
  assign take_write = wr_ok && !swen;
  assign start_ev   = (st == SW_IDLE) && swen && !same_src && tgt_ready;
  assign quit_ev    = (st == SW_IDLE) && swen && !start_ev;
  assign window_end = (st == SW_HOLD) && (cnt == LAST);
  assign commit_ev  = window_end && tgt_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= SW_IDLE;
      cnt     <= '0;
      cur_src <= '0;
      new_src <= '0;
      swen    <= 1'b0;
    end else begin
      if (take_write) begin
        new_src <= new_in;
        swen    <= swen_in;
      end
      if (start_ev) begin
        st  <= SW_HOLD;
        cnt <= '0;
      end
      if (quit_ev) swen <= 1'b0;
      if (st == SW_HOLD && !window_end) cnt <= cnt + 1'b1;
      if (window_end) begin
        st   <= SW_IDLE;
        swen <= 1'b0;
      end
      if (commit_ev) cur_src <= new_src;
    end
  end
endmodule

// File: rtl/clksw_slewer.sv
module clksw_slewer
  import clksw_pkg::*;
#(
  parameter int STEP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ok,
  input  logic [DIV_W-1:0]  tgt_in,
  input  logic [STEP_W-1:0] step_in,
  input  logic              up_in,
  input  logic              dn_in,
  output logic [DIV_W-1:0]  tgt,
  output logic [DIV_W-1:0]  applied,
  output logic [STEP_W-1:0] step,
  output logic              up_en,
  output logic              dn_en,
  output logic              busy
);
  logic [STEP_W-1:0] tick;
  logic slew_ok, tick_done;

  assign busy      = (applied != tgt);
  assign slew_ok   = slew_allowed(applied, tgt, up_en, dn_en);
  assign tick_done = (tick == step);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt     <= '0;
      applied <= '0;
      step    <= '0;
      up_en   <= 1'b0;
      dn_en   <= 1'b0;
      tick    <= '0;
    end else if (wr_ok) begin
      tgt   <= tgt_in;
      step  <= step_in;
      up_en <= up_in;
      dn_en <= dn_in;
      tick  <= '0;
    end else if (busy) begin
      if (!slew_ok) begin
        applied <= tgt;
        tick    <= '0;
      end else if (tick_done) begin
        applied <= step_toward(applied, tgt);
        tick    <= '0;
      end else begin
        tick <= tick + 1'b1;
      end
    end else begin
      tick <= '0;
    end
  end
endmodule

// File: rtl/clksw_top.sv
module clksw_top
  import clksw_pkg::*;
#(
  parameter int SW_LAT = 4,
  parameter int STEP_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        unlock_arm,
  input  logic        wr_en,
  input  logic        wr_addr,
  input  logic [31:0] wr_data,
  input  logic [7:0]  src_ready,
  output logic [31:0] mux_rd,
  output logic [31:0] slew_rd,
  output logic [2:0]  sys_src,
  output logic [4:0]  sys_ratio
);
  logic armed, wr_ok, wr_mux, wr_slew;
  logic [SRC_W-1:0]  cur_src, new_src;
  logic              swen;
  logic [DIV_W-1:0]  tgt, applied;
  logic [STEP_W-1:0] step;
  logic              up_en, dn_en, busy;
  logic              unused_wr;

  assign unused_wr = ^wr_data;
  assign wr_mux    = wr_ok && !wr_addr;
  assign wr_slew   = wr_ok &&  wr_addr;

  clksw_unlock u_unlock (
    .clk(clk), .rst_n(rst_n), .unlock_arm(unlock_arm), .wr_en(wr_en),
    .armed(armed), .wr_ok(wr_ok)
  );

  clksw_switch_fsm #(.SW_LAT(SW_LAT)) u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_mux),
    .new_in(wr_data[NEW_LSB +: SRC_W]), .swen_in(wr_data[SWEN_BIT]),
    .src_ready(src_ready), .cur_src(cur_src), .new_src(new_src), .swen(swen)
  );

  clksw_slewer #(.STEP_W(STEP_W)) u_slew (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_slew),
    .tgt_in(wr_data[DIV_LSB +: DIV_W]), .step_in(wr_data[STEP_LSB +: STEP_W]),
    .up_in(wr_data[UP_BIT]), .dn_in(wr_data[DN_BIT]),
    .tgt(tgt), .applied(applied), .step(step),
    .up_en(up_en), .dn_en(dn_en), .busy(busy)
  );

  always_comb begin
    mux_rd = '0;
    mux_rd[SWEN_BIT]           = swen;
    mux_rd[NEW_LSB +: SRC_W]   = new_src;
    mux_rd[CUR_LSB +: SRC_W]   = cur_src;
    slew_rd = '0;
    slew_rd[BUSY_BIT]          = busy;
    slew_rd[DN_BIT]            = dn_en;
    slew_rd[UP_BIT]            = up_en;
    slew_rd[STEP_LSB +: STEP_W] = step;
    slew_rd[DIV_LSB +: DIV_W]  = tgt;
  end

  assign sys_src   = cur_src;
  assign sys_ratio = ratio_of(applied);
endmodule

// File: rtl/clksw_checker.sv
module clksw_checker #(
  parameter int SW_LAT = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        armed,
  input logic [7:0]  src_ready,
  input logic [31:0] mux_rd,
  input logic [31:0] slew_rd,
  input logic [2:0]  sys_src,
  input logic [4:0]  sys_ratio
);
  int swen_age;
  always_ff @(posedge clk) begin
    if (!rst_n)         swen_age <= 0;
    else if (mux_rd[0]) swen_age <= swen_age + 1;
    else                swen_age <= 0;
  end

  // R2: an unarmed write leaves the writable fields alone
  a_r2_unarmed_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !armed) |=> ($stable(slew_rd[23:1]) && $stable(mux_rd[10:8])));

  // R3: the source only moves when a request was pending
  a_r3_src_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sys_src) |-> $past(mux_rd[0]));

  // R3: the request bit never outlives the settling window
  a_r3_swen_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    swen_age <= SW_LAT + 1);

  // R5: the source only moves to one that was ready at the commit edge
  a_r5_src_was_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sys_src) |-> ((($past(src_ready) >> sys_src) & 8'd1) != 8'd0));

  // R10: with slewing on for the direction, the ratio moves by one
  a_r10_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sys_ratio) &&
     ((sys_ratio > $past(sys_ratio)) ? $past(slew_rd[2]) : $past(slew_rd[1])))
    |-> ((sys_ratio == $past(sys_ratio) + 5'd1) || (sys_ratio + 5'd1 == $past(sys_ratio))));
endmodule

bind clksw_top clksw_checker #(.SW_LAT(SW_LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .armed(armed),
  .src_ready(src_ready), .mux_rd(mux_rd), .slew_rd(slew_rd),
  .sys_src(sys_src), .sys_ratio(sys_ratio)
);

// File: tb/clksw_top_tb.sv
`timescale 1ns/1ps
module clksw_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        unlock_arm = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_addr = 1'b0;
  logic [31:0] wr_data = '0;
  logic [7:0]  src_ready = 8'b0000_0101;
  logic [31:0] mux_rd, slew_rd;
  logic [2:0]  sys_src;
  logic [4:0]  sys_ratio;

  clksw_top u_dut (
    .clk(clk), .rst_n(rst_n), .unlock_arm(unlock_arm), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .src_ready(src_ready),
    .mux_rd(mux_rd), .slew_rd(slew_rd), .sys_src(sys_src), .sys_ratio(sys_ratio)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {int at; int kind; logic [31:0] exp; int req;} exp_t;
  exp_t q[$];

  function automatic logic [31:0] observe(input int kind);
    case (kind)
      0: return mux_rd;
      1: return slew_rd;
      2: return {29'd0, sys_src};
      default: return {27'd0, sys_ratio};
    endcase
  endfunction

  task automatic check(input int kind, input logic [31:0] exp, input int req);
    logic [31:0] act;
    act = observe(kind);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d cyc %0d kind %0d actual %h expected %h", req, cyc, kind, act, exp);
    end
  endtask

  task automatic expect_at(input int at, input int kind, input logic [31:0] exp, input int req);
    exp_t e;
    e.at = at; e.kind = kind; e.exp = exp; e.req = req;
    q.push_back(e);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].at == cyc) begin
        check(q[i].kind, q[i].exp, q[i].req);
        q.delete(i);
      end
    end
  end

  // write driven at negedge cyc c (after optional arm), lands on the next edge
  task automatic wr(input logic a, input logic [31:0] d, input bit arm);
    if (arm) begin
      unlock_arm = 1'b1;
      @(negedge clk);
      unlock_arm = 1'b0;
    end
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    int c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(0, 32'h0, 1);
    check(1, 32'h0, 1);
    check(2, 32'h0, 1);
    check(3, 32'd1, 1);

    // R2: unarmed writes are dropped
    c = cyc;
    expect_at(c + 1, 0, 32'h0, 2);
    expect_at(c + 3, 0, 32'h0, 2);
    expect_at(c + 3, 2, 32'h0, 2);
    wr(1'b0, 32'h0000_0201, 1'b0);
    c = cyc;
    expect_at(c + 1, 1, 32'h0, 2);
    expect_at(c + 2, 3, 32'd1, 2);
    wr(1'b1, 32'h0050_0000, 1'b0);
    drain();

    // R3: switch to ready source 2 after the settling window
    c = cyc + 1;
    expect_at(c + 1, 0, 32'h0000_0201, 3);
    expect_at(c + 5, 0, 32'h0000_0201, 3);
    expect_at(c + 5, 2, 32'd0, 3);
    expect_at(c + 6, 0, 32'h0000_2200, 3);
    expect_at(c + 6, 2, 32'd2, 3);
    wr(1'b0, 32'h0000_0201, 1'b1);
    drain();

    // R4: source 5 not ready, rejected
    c = cyc + 1;
    expect_at(c + 1, 0, 32'h0000_2501, 4);
    expect_at(c + 2, 0, 32'h0000_2500, 4);
    expect_at(c + 3, 2, 32'd2, 4);
    wr(1'b0, 32'h0000_0501, 1'b1);
    drain();

    // R6: same source completes at once
    c = cyc + 1;
    expect_at(c + 1, 0, 32'h0000_2201, 6);
    expect_at(c + 2, 0, 32'h0000_2200, 6);
    wr(1'b0, 32'h0000_0201, 1'b1);
    drain();

    // R5: ready drops during the settling window
    c = cyc + 1;
    expect_at(c + 1, 0, 32'h0000_2001, 5);
    expect_at(c + 5, 0, 32'h0000_2001, 5);
    expect_at(c + 6, 0, 32'h0000_2000, 5);
    expect_at(c + 6, 2, 32'd2, 5);
    wr(1'b0, 32'h0000_0001, 1'b1);
    repeat (2) @(negedge clk);
    src_ready[0] = 1'b0;
    drain();
    src_ready[0] = 1'b1;

    // R7: second write while pending is ignored
    c = cyc + 1;
    expect_at(c + 4, 0, 32'h0000_2001, 7);
    expect_at(c + 6, 0, 32'h0000_0000, 7);
    expect_at(c + 6, 2, 32'd0, 7);
    wr(1'b0, 32'h0000_0001, 1'b1);
    wr(1'b0, 32'h0000_0701, 1'b1);
    drain();

    // R9 R12: no slew enabled, jump from field 0 to 5
    c = cyc + 1;
    expect_at(c + 1, 1, 32'h0050_0001, 12);
    expect_at(c + 1, 3, 32'd1, 9);
    expect_at(c + 2, 1, 32'h0050_0000, 11);
    expect_at(c + 2, 3, 32'd6, 9);
    wr(1'b1, 32'h0050_0000, 1'b1);
    drain();

    // R10 R11: down-slew 5 -> 2, interval 2 (step every 3 edges)
    c = cyc + 1;
    expect_at(c + 3, 3, 32'd6, 10);
    expect_at(c + 4, 3, 32'd5, 10);
    expect_at(c + 6, 3, 32'd5, 10);
    expect_at(c + 7, 3, 32'd4, 10);
    expect_at(c + 9, 1, 32'h0020_0203, 11);
    expect_at(c + 10, 3, 32'd3, 10);
    expect_at(c + 10, 1, 32'h0020_0202, 11);
    wr(1'b1, 32'h0020_0202, 1'b1);
    drain();

    // R10: up-slew 2 -> 6, interval 0 (a step every edge)
    c = cyc + 1;
    expect_at(c + 2, 3, 32'd4, 10);
    expect_at(c + 3, 3, 32'd5, 10);
    expect_at(c + 4, 3, 32'd6, 10);
    expect_at(c + 4, 1, 32'h0060_0005, 11);
    expect_at(c + 5, 3, 32'd7, 10);
    expect_at(c + 5, 1, 32'h0060_0004, 11);
    wr(1'b1, 32'h0060_0004, 1'b1);
    drain();

    // R8: only up-slew set, a downward move jumps
    c = cyc + 1;
    expect_at(c + 1, 1, 32'h0010_0005, 8);
    expect_at(c + 2, 3, 32'd2, 8);
    expect_at(c + 2, 1, 32'h0010_0004, 8);
    wr(1'b1, 32'h0010_0004, 1'b1);
    drain();

    finish_up();
  end
endmodule